// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the storage side of a MAC receive path. Received frames arrive as a stream of 32-bit words. For each frame the block reads the next descriptor of a ring held in memory, writes the frame words into the buffer that descriptor names, and then writes back the descriptor. The write-back puts the byte length and a multicast marker into the second word and raises the ownership (done) flag in the first word. Software hands a descriptor back by clearing its done flag. A descriptor is two words long. Word 0 holds the word-aligned buffer address, with bit 0 as the done flag and bit 1 as the wrap flag. Word 1 (offset 4) holds the length in bits 10:0 and the multicast marker in bit 31. All other bits of word 1 are written as zero.

The ring base address is a plain input that the register block drives. While the receive enable is low, the descriptor pointer follows that base and the block does nothing. If the next descriptor is still marked done when a frame starts, the block pulses a buffer-not-available event, consumes and discards the frame, and counts the drop. The next frame tries the same descriptor again. Memory is reached through a simple port. A request is accepted when `mem_gnt` is high, and read data comes back with `mem_rvalid` some cycles later. Only one access is outstanding at a time.

The frame input is valid/ready. A beat transfers on a rising edge when both `s_valid` and `s_ready` are high. The source must hold the beat stable while `s_ready` is low. During buffer writes `s_ready` is the memory grant, so memory back-pressure passes straight through to the source. `s_ready` stays low while a descriptor is being fetched or written back.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, with the receive enable low, `mem_req`, `s_ready`, `rcom_pulse` and `bna_pulse` are 0 and `drop_count` is 0.
- R2: The first frame after enabling goes to the descriptor at the ring base. Beat k is written to byte address (buffer word with bits 1:0 cleared) + 4*k.
- R3: The length field, bits 10:0 of descriptor word 1, equals the byte count of the frame, FCS included. The count is 4 times (beats - 1) plus `s_bytes` of the last beat, where an `s_bytes` value of 0 means 4.
- R4: Bit 31 of descriptor word 1 holds the value of `s_mcast` on the last beat.
- R5: After the length word, descriptor word 0 is rewritten as the buffer address with bit 0 set and the wrap bit unchanged. `rcom_pulse` is then high for exactly one cycle per stored frame.
- R6: After each stored frame the pointer moves on by 8 bytes. If the used descriptor had its wrap bit (bit 1) set, the pointer returns to the ring base instead.
- R7: If a fetched descriptor has bit 0 set, `bna_pulse` is high for one cycle and the frame is consumed with no memory write. `drop_count` rises by 1 and the next frame fetches the same descriptor again.
- R8: While the receive enable is low the pointer is loaded from `ring_base` and no memory request is made. After re-enabling, reception resumes at the ring base.
- R9: A withheld `mem_grant` stalls the stream through `s_ready` with no loss, duplication or reordering of beats.
- R10: Every memory address the block issues is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; low restarts the ring |
| ring_base | input | AW | Byte address of descriptor 0 |
| s_valid | input | 1 | Frame beat valid |
| s_ready | output | 1 | Frame beat accepted |
| s_data | input | DW | Frame data word |
| s_last | input | 1 | Last beat of frame |
| s_bytes | input | 2 | Valid bytes in last beat, 0 = all four |
| s_mcast | input | 1 | Frame had a multicast destination (read on last beat) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| rcom_pulse | output | 1 | One-cycle receive-complete event |
| bna_pulse | output | 1 | One-cycle buffer-not-available event |
| drop_count | output | DROP_W | Saturating count of dropped frames |

## Verification
The bench fills the whole ring until it comes back to a descriptor that software has not yet released. A design that ignored the done flag would overwrite the first frame's buffer, and one that advanced past the busy descriptor would skip it once it was released. Grant stalls during a multicast frame expose any design that lets a beat through on `s_valid` alone: a word would go missing or be duplicated in the buffer. Frames of one, two, three and five beats with every tail size catch off-by-one errors in the length. A change of ring base while disabled shows whether the pointer is really reloaded from the input rather than left where it stopped.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int DONE_BIT   = 0;
  localparam int WRAP_BIT   = 1;
  localparam int DESC_BYTES = 8;
  localparam int SIZE_OFS   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDREQ,
    ST_RDWAIT,
    ST_DATA,
    ST_DROP,
    ST_WSIZE,
    ST_WADDR
  } rxd_state_e;
endpackage

// File: rtl/rxd_ptr.sv
module rxd_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [AW-1:0] base,
  input  logic          advance,
  input  logic          wrap,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] STEP = AW'(rxd_pkg::DESC_BYTES);

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (restart) ptr_q <= base;
    else if (advance) ptr_q <= wrap ? base : ptr_q + STEP;
  end

  assign ptr = ptr_q;

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ptr == $past(base));
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && !wrap) |=> ptr == $past(ptr) + STEP);
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && wrap) |=> ptr == $past(base));
endmodule

// File: rtl/rxd_len.sv
module rxd_len #(
  parameter int LEN_W = 11,
  parameter int BCW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [BCW-1:0]   tail_bytes,
  output logic [LEN_W-BCW-1:0] widx,
  output logic [LEN_W-1:0] len
);
  localparam int IW = LEN_W - BCW;
  localparam logic [LEN_W-1:0] FULL = LEN_W'(1 << BCW);

  logic [IW-1:0]    idx_q;
  logic [LEN_W-1:0] tail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx_q <= '0;
    else if (clr)  idx_q <= '0;
    else if (step) idx_q <= idx_q + 1'b1;
  end

  always_comb begin
    tail = (tail_bytes == '0) ? FULL : LEN_W'(tail_bytes);
    len  = {idx_q, {BCW{1'b0}}} + tail;
  end

  assign widx = idx_q;

  p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> widx == $past(widx) + 1'b1);
endmodule

// File: rtl/rxd_sat_cnt.sv
module rxd_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (inc && ~&cnt_q)      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  p_drop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int LEN_W  = 11,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [AW-1:0]     ring_base,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DW-1:0]     s_data,
  input  logic              s_last,
  input  logic [$clog2(DW/8)-1:0] s_bytes,
  input  logic              s_mcast,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DW-1:0]     mem_rdata,
  output logic              rcom_pulse,
  output logic              bna_pulse,
  output logic [DROP_W-1:0] drop_count
);
  import rxd_pkg::*;

  localparam int BYTES = DW / 8;
  localparam int BCW   = $clog2(BYTES);
  localparam int IW    = LEN_W - BCW;

  rxd_state_e state_q, state_d;

  logic [AW-1:0]    ptr;
  logic [AW-1:0]    buf_q;
  logic             wrap_q;
  logic [LEN_W-1:0] len_now, len_q;
  logic             mcast_q;
  logic [IW-1:0]    widx;
  logic             rcom_q, bna_q;

  logic fetch_hit, beat_hs, last_hs, drop_last, commit;

  assign fetch_hit = (state_q == ST_RDWAIT) && mem_rvalid;
  assign beat_hs   = (state_q == ST_DATA) && s_valid && mem_gnt;
  assign last_hs   = beat_hs && s_last;
  assign drop_last = (state_q == ST_DROP) && s_valid && s_last;
  assign commit    = (state_q == ST_WADDR) && mem_gnt;

  rxd_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .restart(!rx_en), .base(ring_base),
    .advance(commit), .wrap(wrap_q), .ptr(ptr)
  );

  rxd_len #(.LEN_W(LEN_W), .BCW(BCW)) u_len (
    .clk(clk), .rst_n(rst_n), .clr(fetch_hit), .step(beat_hs),
    .tail_bytes(s_bytes), .widx(widx), .len(len_now)
  );

  rxd_sat_cnt #(.W(DROP_W)) u_drop (
    .clk(clk), .rst_n(rst_n), .inc(drop_last && rx_en), .cnt(drop_count)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (s_valid) state_d = ST_RDREQ;
      ST_RDREQ:  if (mem_gnt) state_d = ST_RDWAIT;
      ST_RDWAIT: if (mem_rvalid)
                   state_d = mem_rdata[DONE_BIT] ? ST_DROP : ST_DATA;
      ST_DATA:   if (last_hs) state_d = ST_WSIZE;
      ST_DROP:   if (drop_last) state_d = ST_IDLE;
      ST_WSIZE:  if (mem_gnt) state_d = ST_WADDR;
      ST_WADDR:  if (mem_gnt) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
    if (!rx_en) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      buf_q   <= '0;
      wrap_q  <= 1'b0;
      len_q   <= '0;
      mcast_q <= 1'b0;
      rcom_q  <= 1'b0;
      bna_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rcom_q  <= rx_en && commit;
      bna_q   <= rx_en && fetch_hit && mem_rdata[DONE_BIT];
      if (fetch_hit) begin
        buf_q  <= {mem_rdata[AW-1:BCW], {BCW{1'b0}}};
        wrap_q <= mem_rdata[WRAP_BIT];
      end
      if (last_hs) begin
        len_q   <= len_now;
        mcast_q <= s_mcast;
      end
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr;
    mem_wdata = '0;
    s_ready   = 1'b0;
    if (rx_en) begin
      unique case (state_q)
        ST_RDREQ: mem_req = 1'b1;
        ST_DATA: begin
          mem_req   = s_valid;
          mem_we    = 1'b1;
          mem_addr  = buf_q + AW'({widx, {BCW{1'b0}}});
          mem_wdata = s_data;
          s_ready   = mem_gnt;
        end
        ST_DROP: s_ready = 1'b1;
        ST_WSIZE: begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = ptr + AW'(SIZE_OFS);
          mem_wdata[LEN_W-1:0] = len_q;
          mem_wdata[DW-1]      = mcast_q;
        end
        ST_WADDR: begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_wdata[AW-1:0]    = buf_q;
          mem_wdata[WRAP_BIT]  = wrap_q;
          mem_wdata[DONE_BIT]  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign rcom_pulse = rcom_q;
  assign bna_pulse  = bna_q;

  p_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[BCW-1:0] == '0);
  p_rcom_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rcom_pulse |-> $past(mem_req && mem_gnt && mem_we && mem_wdata[DONE_BIT]));
  p_bna_not_rcom_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bna_pulse && rcom_pulse));
  p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !$past(rx_en)) |-> (!mem_req && !s_ready));
  p_ready_is_gnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && mem_req) |-> mem_gnt);
endmodule

// File: tb/sim_rx_ring_writer.sv
`timescale 1ns/1ps
module sim_rx_ring_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic [31:0] ring_base = 32'h100;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_data = '0;
  logic        s_last = 1'b0;
  logic [1:0]  s_bytes = '0;
  logic        s_mcast = 1'b0;
  logic        mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rcom_pulse, bna_pulse;
  logic [15:0] drop_count;

  always #4 clk = ~clk;

  rx_ring_writer u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .s_bytes(s_bytes), .s_mcast(s_mcast),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rcom_pulse(rcom_pulse), .bna_pulse(bna_pulse), .drop_count(drop_count)
  );

  logic [31:0] mem [0:255];
  logic        stall_on = 1'b0;
  logic        tog = 1'b0;
  logic        sw_we = 1'b0;
  logic [7:0]  sw_idx = '0;
  logic [31:0] sw_val = '0;
  int          rcom_seen = 0, bna_seen = 0, misaligned = 0;
  int          checks = 0, fails = 0;

  assign mem_gnt = !stall_on || tog;

  always @(posedge clk) begin
    tog <= ~tog;
    mem_rvalid <= mem_req && mem_gnt && !mem_we;
    if (mem_req && mem_gnt && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
    if (mem_req && mem_gnt && mem_we)  mem[mem_addr[9:2]] <= mem_wdata;
    if (sw_we) mem[sw_idx] <= sw_val;
  end

  always @(negedge clk) begin
    if (rcom_pulse) rcom_seen++;
    if (bna_pulse)  bna_seen++;
    if (mem_req && mem_addr[1:0] != 2'b00) misaligned++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sw_write(input int idx, input logic [31:0] val);
    @(negedge clk);
    sw_we = 1'b1; sw_idx = 8'(idx); sw_val = val;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  function automatic logic [31:0] word_of(input int id, input int k);
    return {8'(id), 24'(k)};
  endfunction

  task automatic send_frame(input int id, input int nw, input logic [1:0] tail, input logic mc);
    logic hs;
    for (int k = 0; k < nw; k++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = word_of(id, k);
      s_last  = (k == nw - 1);
      s_bytes = (k == nw - 1) ? tail : 2'd0;
      s_mcast = mc;
      forever begin
        #1 hs = s_ready;
        @(posedge clk);
        if (hs) break;
        @(negedge clk);
      end
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
    repeat (15) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 s_ready", 32'(s_ready), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 pulses", 32'({rcom_pulse, bna_pulse}), 0);
    chk("R1 drop_count", 32'(drop_count), 0);
  endtask

  task automatic t_first_frame;
    send_frame(8'hA1, 5, 2'd2, 1'b0);
    for (int k = 0; k < 5; k++) chk("R2 buffer word", mem[128 + k], word_of(8'hA1, k));
    chk("R3 length 18", mem[65], 32'd18);
    chk("R5 addr word done", mem[64], 32'h201);
    chk("R5 rcom count", 32'(rcom_seen), 1);
  endtask

  task automatic t_stalled_mcast;
    stall_on = 1'b1;
    send_frame(8'hB2, 3, 2'd0, 1'b1);
    stall_on = 1'b0;
    for (int k = 0; k < 3; k++) chk("R9 stalled beat", mem[160 + k], word_of(8'hB2, k));
    chk("R4 mcast size word", mem[67], 32'h8000000C);
    chk("R6 second descriptor", mem[66], 32'h281);
  endtask

  task automatic t_wrap_frame;
    send_frame(8'hC3, 1, 2'd3, 1'b0);
    chk("R2 single beat", mem[192], word_of(8'hC3, 0));
    chk("R3 length 3", mem[69], 32'd3);
    chk("R5 wrap kept", mem[68], 32'h303);
  endtask

  task automatic t_busy_drop;
    send_frame(8'hD4, 2, 2'd0, 1'b0);
    chk("R7 bna count", 32'(bna_seen), 1);
    chk("R7 drop count", 32'(drop_count), 1);
    chk("R7 buffer untouched", mem[128], word_of(8'hA1, 0));
    chk("R7 size untouched", mem[65], 32'd18);
    chk("R7 no rcom", 32'(rcom_seen), 3);
  endtask

  task automatic t_retry;
    sw_write(64, 32'h200);
    send_frame(8'hE5, 2, 2'd1, 1'b0);
    chk("R6 wrapped to base", mem[128], word_of(8'hE5, 0));
    chk("R7 retry second word", mem[129], word_of(8'hE5, 1));
    chk("R3 length 5", mem[65], 32'd5);
    chk("R5 rcom count", 32'(rcom_seen), 4);
  endtask

  task automatic t_restart;
    @(negedge clk);
    rx_en = 1'b0;
    ring_base = 32'h120;
    sw_write(72, 32'h342);
    @(negedge clk);
    rx_en = 1'b1;
    send_frame(8'hF6, 2, 2'd0, 1'b0);
    chk("R8 new base buffer", mem[208], word_of(8'hF6, 0));
    chk("R8 length 8", mem[73], 32'd8);
    chk("R8 desc done", mem[72], 32'h343);
    chk("R8 old desc untouched", mem[67], 32'h8000000C);
    send_frame(8'h77, 1, 2'd0, 1'b0);
    chk("R7 second drop", 32'(drop_count), 2);
    chk("R6 wrap single ring", 32'(bna_seen), 2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    sw_write(64, 32'h200);
    sw_write(66, 32'h280);
    sw_write(68, 32'h302);
    @(negedge clk);
    rx_en = 1'b1;
    t_first_frame;
    t_stalled_mcast;
    t_wrap_frame;
    t_busy_drop;
    t_retry;
    t_restart;
    chk("R10 misaligned addresses", 32'(misaligned), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule